// File: doc/BRIEF.md
# Bidirectional Port with Pin Interrupts

This block is an 8-bit general-purpose I/O port that sits on a small microcontroller's byte bus. Two byte-wide registers control it. A data latch supplies the levels that pins configured as outputs drive. A direction register picks, for each pin on its own, whether the pin drives its pad or only samples it. The block drives a level and an output enable toward every pad and reads every pad back through a two-flop synchronizer.

Each pin has its own pullup-enable configuration input. When a pullup-enabled pin is an input, its synchronized level joins the external interrupt line in one active-low wired-AND. The merged line feeds a single detector with two modes. In edge mode a falling edge latches a pending flag, which stays until a one-cycle acknowledge. In edge-and-level mode the request also stays asserted for as long as the merged line is low.

Bit 7 can be handed to a PWM generator. While it is handed over, that pad drives the PWM level and never counts as an interrupt source. Software must set a pin's data bit to 1 before it turns that pin from an output into an input, so that no interrupt fires on the switch.

Top module: `gpio_port_irq`

## Requirements
- R1: After a synchronous reset the direction register reads 0, every pad output enable is 0 while the PWM selection is off, and irq_req_n is 1.
- R2: A write with bus_wr=1 at address 0x02 loads the data latch, and a write at address 0x06 loads the direction register. A write to any other address changes neither, and a read of any other address returns 0x00.
- R3: A direction bit of 1 sets the pad's output enable to 1 and drives the pad with the data latch bit. A direction bit of 0 clears the output enable.
- R4: Reset leaves the data latch contents unchanged.
- R5: A read at 0x02 returns, for each bit, the data latch bit when its direction bit is 1 and the synchronized pad level when it is 0. A read at 0x06 returns the direction register.
- R6: In edge mode (edge_level_mode=0), a falling edge on an input pin whose pullup_en bit is 1 drives irq_req_n low. irq_req_n stays low after the pin returns high and goes high only after an irq_ack pulse.
- R7: A pin whose pullup_en bit is 0, or whose direction bit is 1, raises no interrupt, whatever its pad level.
- R8: In edge-and-level mode (edge_level_mode=1), irq_req_n stays low while the merged line is low, even after irq_ack. It returns high once the sources release and the pending flag has been acknowledged.
- R9: A falling edge on the external irq_pad_n raises the same pending request as a port pin.
- R10: With pwm_sel=1, pad 7 has its output enable at 1 and drives pwm_in. Pin 7 raises no interrupt even if its pullup_en bit is 1 and its direction bit is 0.
- R11: Switching a pullup-enabled pin from output to input while its data bit is 1 raises no interrupt, because the pad stays high.
- R12: irq_req_n can rise after having been low in edge mode only in the cycle after an irq_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Pad levels as seen at the pins |
| pad_out | output | 8 | Levels driven toward the pads |
| pad_oe | output | 8 | Per-pad output enable |
| pullup_en | input | 8 | Per-pin pullup configuration; a 1 makes an input pin an interrupt source |
| pwm_sel | input | 1 | Hands pin 7 to the PWM generator |
| pwm_in | input | 1 | PWM level for pin 7 |
| irq_pad_n | input | 1 | External active-low interrupt line |
| edge_level_mode | input | 1 | 0 = edge only, 1 = edge and level |
| irq_ack | input | 1 | One-cycle acknowledge that clears the pending flag |
| irq_req_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that the configuration inputs edge_level_mode, pullup_en and pwm_sel change only while the merged interrupt line is idle. They also assume that irq_ack is a single-cycle pulse and that the pads model a pullup, so a released input reads 1. The bench changes its configuration between scenarios while no pin is pulled low. It models every pad as the driven level when its output enable is 1, and as high unless the bench pulls it low otherwise. Every external low pulse lasts three cycles, so the synchronizer always sees it.

// File: rtl/gpio_port_pkg.sv
// Package: shared types for the bidirectional port.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package gpio_port_pkg;

    // Sensitivity of the merged interrupt detector.
    typedef enum logic {
        SENSE_EDGE       = 1'b0,
        SENSE_EDGE_LEVEL = 1'b1
    } sense_e;

endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// A multi-bit two-flop synchronizer. Every bit is synchronized on its own;
// the output is not coherent across bits.
// Assumes: inputs are asynchronous and change slowly compared with clk.
module gpio_sync #(
    parameter int   WIDTH   = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // Two flops in series; reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= {WIDTH{RST_VAL}};
            stage2 <= {WIDTH{RST_VAL}};
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

endmodule

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Holds the data latch and the direction register, decodes bus writes,
// forms the read data and drives the pads. The PWM pin variant is picked
// per bit by a generate branch.
// Assumes: pad_sync is already synchronized; bus writes are single cycle.
module gpio_regs #(
    parameter int                WIDTH     = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h02,
    parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h06,
    parameter int                PWM_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  pad_sync,
    input  logic              pwm_sel,
    input  logic              pwm_in,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  dir_q
);

    logic [WIDTH-1:0] data_q;
    logic             hit_data;
    logic             hit_dir;

    assign hit_data = (bus_addr == DATA_ADDR);
    assign hit_dir  = (bus_addr == DIR_ADDR);

    // Data latch: loaded by bus writes only, untouched by reset.
    always_ff @(posedge clk) begin
        if (bus_wr && hit_data) begin
            data_q <= bus_wdata;
        end
    end

    // Direction register: cleared by reset, so all pins start as inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (bus_wr && hit_dir) begin
            dir_q <= bus_wdata;
        end
    end

    // Read mux: output pins return the latch, input pins return the pad.
    always_comb begin
        if (hit_data) begin
            bus_rdata = (dir_q & data_q) | (~dir_q & pad_sync);
        end else if (hit_dir) begin
            bus_rdata = dir_q;
        end else begin
            bus_rdata = '0;
        end
    end

    // Pad drive, one slice per pin; the PWM pin takes an override.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i == PWM_BIT) begin : g_pwm
            assign pad_out[i] = pwm_sel ? pwm_in : data_q[i];
            assign pad_oe[i]  = pwm_sel | dir_q[i];
        end else begin : g_plain
            assign pad_out[i] = data_q[i];
            assign pad_oe[i]  = dir_q[i];
        end
    end

endmodule

// File: rtl/gpio_irq_merge.sv
// Module: gpio_irq_merge
// Picks the port pins that act as interrupt sources, ANDs them with the
// external line (all active low), detects falling edges into a pending
// flag and forms the active-low request under the selected sensitivity.
// Assumes: all line inputs are synchronized; irq_ack is a one-cycle pulse.
module gpio_irq_merge
    import gpio_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int PWM_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_sync,
    input  logic             irq_sync,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pullup_en,
    input  logic             pwm_sel,
    input  sense_e           mode,
    input  logic             irq_ack,
    output logic             comb_n,
    output logic             pending,
    output logic             irq_req_n
);

    logic [WIDTH-1:0] src_en;
    logic             comb_prev;
    logic             fall;

    // Source qualification per pin; the PWM pin drops out while assigned.
    for (genvar i = 0; i < WIDTH; i++) begin : g_src
        if (i == PWM_BIT) begin : g_pwm
            assign src_en[i] = pullup_en[i] & ~dir_q[i] & ~pwm_sel;
        end else begin : g_plain
            assign src_en[i] = pullup_en[i] & ~dir_q[i];
        end
    end

    // Wired-AND of the external line and every qualified pin.
    assign comb_n = irq_sync & (&(pad_sync | ~src_en));
    assign fall   = comb_prev & ~comb_n;

    // Previous merged level, idle high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comb_prev <= 1'b1;
        end else begin
            comb_prev <= comb_n;
        end
    end

    // Pending flag: a new edge wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (fall) begin
            pending <= 1'b1;
        end else if (irq_ack) begin
            pending <= 1'b0;
        end
    end

    assign irq_req_n = ~(pending | ((mode == SENSE_EDGE_LEVEL) & ~comb_n));

endmodule

// File: rtl/gpio_port_irq.sv
// Module: gpio_port_irq (top)
// Bidirectional 8-bit port with a data latch, a direction register,
// pullup-qualified pin interrupts merged with an external line, and a PWM
// takeover of one pin.
// Assumes: pad_in and irq_pad_n are asynchronous to clk.
module gpio_port_irq
    import gpio_port_pkg::*;
#(
    parameter int                WIDTH     = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h02,
    parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h06,
    parameter int                PWM_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    input  logic [WIDTH-1:0]  pullup_en,
    input  logic              pwm_sel,
    input  logic              pwm_in,
    input  logic              irq_pad_n,
    input  logic              edge_level_mode,
    input  logic              irq_ack,
    output logic              irq_req_n
);

    localparam int SYNC_W = WIDTH + 1;

    logic [SYNC_W-1:0] sync_q;
    logic [WIDTH-1:0]  pad_sync;
    logic              irq_sync;
    logic [WIDTH-1:0]  dir_q;
    logic              comb_n;
    logic              pending;

    // One synchronizer for the pads and the external line together.
    gpio_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({irq_pad_n, pad_in}),
        .q     (sync_q)
    );

    assign pad_sync = sync_q[WIDTH-1:0];
    assign irq_sync = sync_q[WIDTH];

    gpio_regs #(
        .WIDTH     (WIDTH),
        .ADDR_W    (ADDR_W),
        .DATA_ADDR (DATA_ADDR),
        .DIR_ADDR  (DIR_ADDR),
        .PWM_BIT   (PWM_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pad_sync  (pad_sync),
        .pwm_sel   (pwm_sel),
        .pwm_in    (pwm_in),
        .bus_rdata (bus_rdata),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .dir_q     (dir_q)
    );

    gpio_irq_merge #(
        .WIDTH   (WIDTH),
        .PWM_BIT (PWM_BIT)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_sync  (pad_sync),
        .irq_sync  (irq_sync),
        .dir_q     (dir_q),
        .pullup_en (pullup_en),
        .pwm_sel   (pwm_sel),
        .mode      (sense_e'(edge_level_mode)),
        .irq_ack   (irq_ack),
        .comb_n    (comb_n),
        .pending   (pending),
        .irq_req_n (irq_req_n)
    );

endmodule

// File: rtl/gpio_port_irq_chk.sv
// Module: gpio_port_irq_chk
// Temporal checks on the port, bound to gpio_port_irq.
// Assumes: irq_ack is a single-cycle pulse; the configuration is stable
// around interrupt activity.
module gpio_port_irq_chk #(
    parameter int                WIDTH    = 8,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h06,
    parameter int                PWM_BIT  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  pad_oe,
    input logic              edge_level_mode,
    input logic              irq_ack,
    input logic              irq_req_n
);

    localparam logic [WIDTH-1:0] NOPWM = ~(WIDTH'(1) << PWM_BIT);

    logic seen_clk;

    // Marks that at least one clock edge has passed.
    always_ff @(posedge clk) begin
        seen_clk <= 1'b1;
    end

    // R1
    always_ff @(posedge clk) begin
        if (seen_clk === 1'b1 && $past(rst_n) === 1'b0) begin
            reset_state_chk: assert (irq_req_n && ((pad_oe & NOPWM) == '0));
        end
    end

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_ADDR) |=>
            ((pad_oe & NOPWM) == ($past(bus_wdata) & NOPWM)));

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == DIR_ADDR) |=> $stable(pad_oe & NOPWM));

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req_n && !irq_ack && !edge_level_mode) |=> !irq_req_n);

    // R12
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_n) |-> ($past(irq_ack) || $past(edge_level_mode)));

endmodule

bind gpio_port_irq gpio_port_irq_chk #(
    .WIDTH    (WIDTH),
    .ADDR_W   (ADDR_W),
    .DIR_ADDR (DIR_ADDR),
    .PWM_BIT  (PWM_BIT)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_wdata       (bus_wdata),
    .pad_oe          (pad_oe),
    .edge_level_mode (edge_level_mode),
    .irq_ack         (irq_ack),
    .irq_req_n       (irq_req_n)
);

// File: tb/sim_gpio_port_irq.sv
`timescale 1ns/1ps
module sim_gpio_port_irq;

    localparam logic [7:0] A_DATA = 8'h02;
    localparam logic [7:0] A_DIR  = 8'h06;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] pullup_en = 8'h00;
    logic       pwm_sel = 1'b0;
    logic       pwm_in = 1'b0;
    logic       irq_pad_n = 1'b1;
    logic       edge_level_mode = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req_n;
    logic [7:0] ext_low = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Pad model: a driven pad shows its driver, otherwise pulled high
    // unless the bench holds it low.
    for (genvar i = 0; i < 8; i++) begin : g_pad
        assign pad_in[i] = pad_oe[i] ? pad_out[i] : ~ext_low[i];
    end

    gpio_port_irq u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pullup_en(pullup_en),
        .pwm_sel(pwm_sel), .pwm_in(pwm_in), .irq_pad_n(irq_pad_n),
        .edge_level_mode(edge_level_mode), .irq_ack(irq_ack),
        .irq_req_n(irq_req_n)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(A_DIR, r);
        check("R1 dir", r, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 irq", irq_req_n, 1'b1);

        // R2: unmapped addresses read zero and writes there do nothing
        wr(A_DATA, 8'h3C);
        wr(A_DIR, 8'h0F);
        for (int a = 0; a < 256; a++) begin
            if (a != A_DATA && a != A_DIR) begin
                wr(8'(a), 8'hFF);
                rd(8'(a), r);
                check("R2 unmapped read", r, 8'h00);
            end
        end
        rd(A_DIR, r);
        check("R2 dir kept", r, 8'h0F);
        check("R2 data kept", pad_out & 8'h0F, 8'h0C);

        // R3 R5 R7: sweep every direction value with pullups off
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dv, dat, lo, expr;
            dv  = 8'(d);
            dat = dv ^ 8'h5A;
            lo  = {dv[3:0], dv[7:4]};
            ext_low = lo;
            wr(A_DATA, dat);
            wr(A_DIR, dv);
            settle(3);
            check("R3 oe", pad_oe, dv);
            check("R3 out", pad_out & dv, dat & dv);
            expr = (dv & dat) | (~dv & ~lo);
            rd(A_DATA, r);
            check("R5 data read", r, expr);
            rd(A_DIR, r);
            check("R5 dir read", r, dv);
            check("R7 no source", irq_req_n, 1'b1);
        end
        ext_low = 8'h00;
        wr(A_DIR, 8'h00);
        settle(4);

        // R6 R7: edge mode, one pin at a time
        edge_level_mode = 1'b0;
        for (int i = 0; i < 8; i++) begin
            pullup_en = 8'(1 << i);
            settle(2);
            ext_low = 8'(1 << ((i + 1) % 8));
            settle(3);
            ext_low = 8'h00;
            settle(4);
            check("R7 pullup off", irq_req_n, 1'b1);
            ext_low = 8'(1 << i);
            settle(3);
            ext_low = 8'h00;
            settle(4);
            check("R6 pending", irq_req_n, 1'b0);
            ack();
            settle(1);
            check("R6 ack", irq_req_n, 1'b1);
        end

        // R7: pullup on but pin is an output driving high
        wr(A_DATA, 8'hFF);
        wr(A_DIR, 8'hFF);
        pullup_en = 8'hFF;
        ext_low = 8'hFF;
        settle(5);
        check("R7 output pin", irq_req_n, 1'b1);
        ext_low = 8'h00;

        // R11: output high switched back to input
        wr(A_DIR, 8'h00);
        settle(5);
        check("R11 no irq", irq_req_n, 1'b1);

        // R8: edge and level mode
        edge_level_mode = 1'b1;
        pullup_en = 8'h10;
        ext_low = 8'h10;
        settle(4);
        check("R8 low", irq_req_n, 1'b0);
        ack();
        settle(2);
        check("R8 held by level", irq_req_n, 1'b0);
        ext_low = 8'h00;
        settle(4);
        check("R8 released", irq_req_n, 1'b1);
        edge_level_mode = 1'b0;
        pullup_en = 8'h00;

        // R9: external line
        irq_pad_n = 1'b0;
        settle(3);
        irq_pad_n = 1'b1;
        settle(4);
        check("R9 ext", irq_req_n, 1'b0);
        ack();
        settle(1);
        check("R9 ack", irq_req_n, 1'b1);

        // R10: PWM takeover of pin 7
        pullup_en = 8'h80;
        pwm_sel = 1'b1;
        for (int k = 0; k < 4; k++) begin
            pwm_in = k[0];
            settle(4);
            check("R10 oe", pad_oe[7], 1'b1);
            check("R10 out", pad_out[7], k[0]);
            check("R10 no irq", irq_req_n, 1'b1);
        end
        pwm_sel = 1'b0;
        pwm_in = 1'b0;
        pullup_en = 8'h00;
        settle(4);

        // R4: data latch survives reset
        wr(A_DATA, 8'hA5);
        @(negedge clk) rst_n = 1'b0;
        settle(2);
        rst_n = 1'b1;
        rd(A_DIR, r);
        check("R1 dir after reset", r, 8'h00);
        wr(A_DIR, 8'hFF);
        settle(1);
        check("R4 data kept", pad_out, 8'hA5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule